// File: doc/BRIEF.md
# Performance-Goal Voltage/Frequency Governor

This block chooses the operating point of a processor core at a fixed cadence. A free-running interval timer starts each evaluation. At that moment the block samples two values: the instruction throughput the core reached during the last interval, and the throughput software wants. It scales the present clock frequency by the ratio of the wanted throughput to the reached throughput. The result is a target frequency in MHz.

A switch is made only when the target is far enough from the present frequency. In that case the block holds fetch and waits for the pipeline to report that it is empty. It then moves to the lowest table level that can deliver the target and lets fetch run again. The level table is supplied on input pins and holds frequencies in ascending order. The level index doubles as the selector for the matching supply-voltage setting.

A mode input can pin the core to the fastest or the slowest table entry instead of following the ratio. The division runs over many cycles in a shift-subtract divider. While an evaluation, a division or a drain is in progress, further timer expiries are dropped.

Top module: `dvfs_governor`

## Requirements
- R1: During and right after reset, `fetch_stall_o` is 0, `level_o` is the top index (LEVELS-1) and `freq_o` shows the top table entry.
- R2: An evaluation starts only on a timer expiry, which occurs every INTERVAL cycles. The first expiry falls on the INTERVAL-th rising edge after reset is released.
- R3: In automatic mode with a nonzero observed count, the target is floor(current_freq * goal_i / observed_i). When the quotient exceeds the FREQ_W-bit range, the target is the all-ones FREQ_W-bit value.
- R4: A switch happens only when |target - current_freq| is strictly greater than MARGIN (33 MHz). A difference of exactly 33 causes no switch.
- R5: On a switch, `fetch_stall_o` goes high and stays high until a rising edge at which `drained_i` is 1. At that edge `fetch_stall_o` falls and the new level is applied. The level never changes at any other time.
- R6: The new level is the smallest index k whose entry is at least the target. If no entry is large enough, the top index is used. Entry k sits at bits [k*FREQ_W +: FREQ_W] of `table_freq_i`, and entries ascend with k.
- R7: `mode_i` = 2'b01 makes the target the top entry. `mode_i` = 2'b10 makes the target entry 0. The values 2'b00 and 2'b11 select automatic mode.
- R8: In automatic mode, an observed count of zero makes the target the top entry and starts no division.
- R9: Timer expiries that occur while an evaluation, a division or a drain is in progress are dropped. They do not queue.
- R10: `freq_o` always equals the table entry selected by `level_o`.
- R11: The switch decision is registered NUM_W+2 cycles after the expiry when a division runs, where NUM_W = FREQ_W+CNT_W. Without a division it is registered 1 cycle after the expiry. The stall becomes visible after the edge that registers the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00/11 automatic, 01 fixed fastest, 10 fixed slowest |
| goal_i | input | CNT_W | Wanted instruction throughput |
| observed_i | input | CNT_W | Reached instruction throughput over the last interval |
| drained_i | input | 1 | Pipeline empty while fetch is held |
| table_freq_i | input | LEVELS*FREQ_W | Level frequencies in MHz, ascending, entry k at k*FREQ_W |
| fetch_stall_o | output | 1 | Hold instruction fetch |
| level_o | output | IDX_W | Applied level index, also selects the voltage |
| freq_o | output | FREQ_W | Frequency of the applied level in MHz |

## Verification
The ratio path is driven with four kinds of ratio. Halving and three-eighths ratios give exact targets. The ratios 433/400 and 434/400 sit on either side of the margin. The last kind is a huge goal against a unit count, which tells a correct quotient apart from one that wrapped instead of saturating. A ratio of 5/2 gives a target above every table entry and shows whether the top level is clamped. Both fixed modes and a zero observed count are applied from opposite ends of the table, which separates the bypass targets from ordinary divisions. A drain held longer than one interval shows whether expiries during a busy period are dropped or queued, and the first stall after reset pins down the divider latency.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO     = 2'b00,
    MODE_FMAX     = 2'b01,
    MODE_FMIN     = 2'b10,
    MODE_AUTO_ALT = 2'b11
  } vf_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV,
    ST_DECIDE,
    ST_DRAIN
  } gov_state_e;
endpackage

// File: rtl/dvfs_tick_timer.sv
module dvfs_tick_timer #(
  parameter int unsigned INTERVAL = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= tick_o ? '0 : cnt_q + CW'(1);
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/dvfs_seq_div.sv
module dvfs_seq_div #(
  parameter int unsigned NUM_W = 40,
  parameter int unsigned DEN_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_q;
  logic [DEN_W:0]   rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [DEN_W:0]   rem_sh;
  logic [DEN_W:0]   rem_sub;

  assign rem_sh  = {rem_q[DEN_W-1:0], q_q[NUM_W-1]};
  assign rem_sub = rem_sh - {1'b0, den_q};
  assign done_o  = run_q && (cnt_q == '0);
  assign quot_o  = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      q_q   <= num_i;
      rem_q <= '0;
      den_q <= den_i;
      cnt_q <= CNT_W'(NUM_W);
      run_q <= 1'b1;
    end else if (run_q && cnt_q != '0) begin
      // borrow in the top bit means the shifted remainder is below the divisor
      if (!rem_sub[DEN_W]) begin
        rem_q <= rem_sub;
        q_q   <= {q_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_q <= rem_sh;
        q_q   <= {q_q[NUM_W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (run_q) begin
      run_q <= 1'b0;
    end
  end

  // R9
  div_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q);

  // R11
  div_done_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/dvfs_level_pick.sv
module dvfs_level_pick #(
  parameter int unsigned LEVELS = 8,
  parameter int unsigned FREQ_W = 16,
  parameter int unsigned IDX_W  = $clog2(LEVELS)
) (
  input  logic [LEVELS*FREQ_W-1:0] table_i,
  input  logic [FREQ_W-1:0]        target_i,
  output logic [IDX_W-1:0]         idx_o
);
  logic [LEVELS-1:0] fits;

  for (genvar k = 0; k < LEVELS; k++) begin : g_fit
    assign fits[k] = (table_i[k*FREQ_W +: FREQ_W] >= target_i);
  end

  // lowest fitting entry wins, top entry when none fits
  always_comb begin
    idx_o = IDX_W'(LEVELS - 1);
    for (int k = LEVELS - 1; k >= 0; k--) begin
      if (fits[k]) idx_o = IDX_W'(k);
    end
  end
endmodule

// File: rtl/dvfs_governor.sv
module dvfs_governor
  import dvfs_pkg::*;
#(
  parameter int unsigned FREQ_W   = 16,
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned LEVELS   = 8,
  parameter int unsigned INTERVAL = 64,
  parameter int unsigned MARGIN   = 33,
  parameter int unsigned IDX_W    = $clog2(LEVELS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic [CNT_W-1:0]         goal_i,
  input  logic [CNT_W-1:0]         observed_i,
  input  logic                     drained_i,
  input  logic [LEVELS*FREQ_W-1:0] table_freq_i,
  output logic                     fetch_stall_o,
  output logic [IDX_W-1:0]         level_o,
  output logic [FREQ_W-1:0]        freq_o
);
  localparam int unsigned NUM_W = FREQ_W + CNT_W;

  gov_state_e        state_q;
  vf_mode_e          mode;
  logic [FREQ_W-1:0] tbl [LEVELS];
  logic [FREQ_W-1:0] cur_freq;
  logic [FREQ_W-1:0] target_q;
  logic [FREQ_W-1:0] bypass_target;
  logic [FREQ_W-1:0] quot_sat;
  logic [FREQ_W-1:0] gap;
  logic [IDX_W-1:0]  level_q;
  logic [IDX_W-1:0]  pend_q;
  logic [IDX_W-1:0]  pick_idx;
  logic [NUM_W-1:0]  quot;
  logic              stall_q;
  logic              tick;
  logic              auto_mode;
  logic              bypass;
  logic              eval_go;
  logic              div_start;
  logic              div_done;
  logic              do_switch;

  for (genvar k = 0; k < LEVELS; k++) begin : g_tbl
    assign tbl[k] = table_freq_i[k*FREQ_W +: FREQ_W];
  end

  dvfs_tick_timer #(.INTERVAL(INTERVAL)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign mode          = vf_mode_e'(mode_i);
  assign cur_freq      = tbl[level_q];
  assign auto_mode     = (mode == MODE_AUTO) || (mode == MODE_AUTO_ALT);
  assign bypass        = !auto_mode || (observed_i == '0);
  assign bypass_target = (mode == MODE_FMIN) ? tbl[0] : tbl[LEVELS-1];
  assign eval_go       = tick && (state_q == ST_IDLE);
  assign div_start     = eval_go && !bypass;

  dvfs_seq_div #(.NUM_W(NUM_W), .DEN_W(CNT_W)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (NUM_W'(cur_freq) * NUM_W'(goal_i)),
    .den_i   (observed_i),
    .done_o  (div_done),
    .quot_o  (quot)
  );

  assign quot_sat  = (|quot[NUM_W-1:FREQ_W]) ? '1 : quot[FREQ_W-1:0];
  assign gap       = (target_q >= cur_freq) ? (target_q - cur_freq) : (cur_freq - target_q);
  assign do_switch = (gap > FREQ_W'(MARGIN));

  dvfs_level_pick #(.LEVELS(LEVELS), .FREQ_W(FREQ_W), .IDX_W(IDX_W)) i_pick (
    .table_i  (table_freq_i),
    .target_i (target_q),
    .idx_o    (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
      level_q  <= IDX_W'(LEVELS - 1);
      pend_q   <= '0;
      stall_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (eval_go) begin
          if (bypass) begin
            target_q <= bypass_target;
            state_q  <= ST_DECIDE;
          end else begin
            state_q  <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          target_q <= quot_sat;
          state_q  <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (do_switch) begin
            pend_q  <= pick_idx;
            stall_q <= 1'b1;
            state_q <= ST_DRAIN;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_DRAIN: if (drained_i) begin
          level_q <= pend_q;
          stall_q <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fetch_stall_o = stall_q;
  assign level_o       = level_q;
  assign freq_o        = tbl[level_q];

  // R5
  level_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != $past(level_q)) |-> ($past(fetch_stall_o) && $past(drained_i)));

  // R5
  resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fetch_stall_o) |-> $past(drained_i));

  // R5
  drain_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN) |-> fetch_stall_o);

  // R4
  margin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_stall_o) |-> (gap > FREQ_W'(MARGIN)));

  // R6
  pick_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECIDE) |-> ((pick_idx == IDX_W'(LEVELS - 1)) || (tbl[pick_idx] >= target_q)));
endmodule

// File: tb/test_dvfs_governor.sv
`timescale 1ns/1ps
module test_dvfs_governor;
  localparam int FREQ_W = 16;
  localparam int CNT_W  = 24;
  localparam int LEVELS = 8;
  localparam int INTERVAL = 64;
  localparam int MARGIN = 33;
  localparam int NUM_W = FREQ_W + CNT_W;
  localparam int TOP = LEVELS - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [CNT_W-1:0] goal = 24'd1000;
  logic [CNT_W-1:0] obs = 24'd1000;
  logic drained = 1'b0;
  logic [LEVELS*FREQ_W-1:0] tbl_bus;
  logic stall;
  logic [2:0] level;
  logic [FREQ_W-1:0] freq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int drain_delay = 5;
  int stall_cnt = 0;

  // reference model state
  int m_tcnt, m_phase, m_wait, m_level, m_pend, evals;
  bit m_stall;
  longint m_target;

  always #2 clk = ~clk;

  function automatic int tfreq(int k);
    return 100 * (k + 1);
  endfunction

  function automatic int pick(longint t);
    for (int k = 0; k < LEVELS; k++) if (tfreq(k) >= t) return k;
    return TOP;
  endfunction

  initial for (int k = 0; k < LEVELS; k++) tbl_bus[k*FREQ_W +: FREQ_W] = FREQ_W'(tfreq(k));

  dvfs_governor i_dvfs_governor (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .goal_i(goal), .observed_i(obs),
    .drained_i(drained), .table_freq_i(tbl_bus),
    .fetch_stall_o(stall), .level_o(level), .freq_o(freq)
  );

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tcnt = 0; m_phase = 0; m_wait = 0; m_level = TOP; m_pend = 0; m_stall = 0; evals = 0;
    end else begin
      bit tk;
      longint diff;
      tk = (m_tcnt == INTERVAL - 1);
      m_tcnt = tk ? 0 : m_tcnt + 1;
      case (m_phase)
        0: if (tk) begin
          evals++;
          if (mode == 2'b01)      begin m_target = tfreq(TOP); m_wait = 1; end
          else if (mode == 2'b10) begin m_target = tfreq(0);   m_wait = 1; end
          else if (obs == 0)      begin m_target = tfreq(TOP); m_wait = 1; end
          else begin
            m_target = (longint'(tfreq(m_level)) * longint'(goal)) / longint'(obs);
            if (m_target > 65535) m_target = 65535;
            m_wait = NUM_W + 2;
          end
          m_phase = 1;
        end
        1: begin
          m_wait--;
          if (m_wait == 0) begin
            diff = m_target - tfreq(m_level);
            if (diff < 0) diff = -diff;
            if (diff > MARGIN) begin
              m_stall = 1; m_pend = pick(m_target); m_phase = 2;
            end else m_phase = 0;
          end
        end
        default: if (drained) begin
          m_level = m_pend; m_stall = 0; m_phase = 0;
        end
      endcase
    end
  end

  // per-cycle comparison and drain responder, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R5 fetch_stall_o", stall, m_stall);
      check("R6 level_o", level, m_level);
      check("R10 freq_o", freq, tfreq(int'(level)));
      stall_cnt = stall ? stall_cnt + 1 : 0;
      drained = stall && (stall_cnt >= drain_delay);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_case(input logic [1:0] md, input int g, input int o);
    int ev0, t;
    @(negedge clk);
    ev0 = evals;
    mode = md; goal = CNT_W'(g); obs = CNT_W'(o);
    t = 0;
    while (evals == ev0 && t < 1000) begin @(negedge clk); t++; end
    mode = 2'b00; goal = 24'd1000; obs = 24'd1000;
    t = 0;
    while (m_phase != 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 stall in reset", stall, 0);
    check("R1 level in reset", level, TOP);
    check("R1 freq in reset", freq, 800);
    goal = 24'd1; obs = 24'd2;
    rst_n = 1'b1;
    // R2 R11 first expiry at edge INTERVAL, stall after NUM_W+2 more edges
    n = 0;
    while (!stall && n < 1000) begin @(negedge clk); n++; end
    check("R2 R11 edges to first stall", n, INTERVAL + NUM_W + 2);
    goal = 24'd1000; obs = 24'd1000;
    while (m_phase != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R3 halving ratio level", level, 3);
    check("R10 halving ratio freq", freq, 400);

    run_case(2'b00, 1000, 1000);
    check("R4 neutral ratio keeps level", level, 3);
    run_case(2'b00, 433, 400);
    check("R4 gap of 33 no switch", level, 3);
    run_case(2'b00, 434, 400);
    check("R4 R6 gap of 34 switches to 500", level, 4);
    run_case(2'b10, 1000, 1000);
    check("R7 fixed slowest", level, 0);
    run_case(2'b01, 1000, 1000);
    check("R7 fixed fastest", level, TOP);
    run_case(2'b00, 1, 8);
    check("R3 ratio 1/8 from 800", level, 0);
    run_case(2'b00, 1000, 0);
    check("R8 zero observed goes top", level, TOP);

    // R9 drain longer than an interval: expiries in between are dropped
    drain_delay = 150;
    begin
      int ev0;
      @(negedge clk);
      ev0 = evals;
      goal = 24'd3; obs = 24'd8;
      while (!stall) @(negedge clk);
      goal = 24'd1000; obs = 24'd1000;
      repeat (100) @(negedge clk);
      check("R9 stall held across expiry", stall, 1);
      check("R9 level untouched during drain", level, TOP);
      while (stall) @(negedge clk);
      check("R9 one evaluation only", evals - ev0, 1);
      check("R3 ratio 3/8 from 800", level, 2);
    end
    drain_delay = 3;
    while (m_phase != 0) @(negedge clk);

    run_case(2'b00, 1, 3);
    check("R3 ratio 1/3 from 300", level, 0);
    run_case(2'b00, 16777215, 1);
    check("R3 saturated target goes top", level, TOP);
    run_case(2'b00, 1, 2);
    check("R3 halving again", level, 3);
    run_case(2'b11, 5, 2);
    check("R6 R7 target above table clamps top", level, TOP);
    check("R10 clamped freq", freq, 800);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule